// File: doc/BRIEF.md
# Serial Flash Power-Up Reset and Density Check Sequencer

This block runs once per launch to bring a serial page-organised flash device out of reset and confirm that the part fitted has the storage size the system was built for. It keeps the device's active-low write-protect pin released, which leaves writes enabled. It then drives a reset pulse with chip select held low and waits a fixed settling interval. After that it reads the device status byte through a byte-exchange port that is shared with an external SPI shifter. A 4-bit size code is taken from the status byte and compared with a build-time parameter.

A one-cycle `start` pulse launches the sequence. When it finishes, `seq_done` rises and exactly one of `dev_pass` / `dev_fail` is set, and the raw status byte is presented. These results hold until the next accepted `start` or a reset. Both timed intervals are derived from the clock frequency parameter and rounded up to whole cycles. The state machine walks through these states in order: IDLE, ARM, RST_PULSE, SETTLE, CS_GAP, OP_ISSUE, OP_WAIT, DUM_ISSUE, DUM_WAIT, JUDGE, DONE.

Its transitions are as follows. IDLE→ARM and DONE→ARM happen on `start`. ARM→RST_PULSE is unconditional. RST_PULSE→SETTLE and SETTLE→CS_GAP happen when the interval timer expires. CS_GAP→OP_ISSUE is unconditional. OP_ISSUE→OP_WAIT and DUM_ISSUE→DUM_WAIT are unconditional. OP_WAIT→DUM_ISSUE and DUM_WAIT→JUDGE happen on `xfer_done`. JUDGE→DONE is unconditional.

Top module: `flash_bringup`

## Requirements
- R1: After reset, `flash_rst_n`, `flash_wp_n` and `flash_cs_n` are high, and `xfer_start`, `seq_done`, `dev_pass` and `dev_fail` are low. `flash_wp_n` is high at all times.
- R2: After `start` is accepted in IDLE, `flash_rst_n` is low for exactly TICKS consecutive cycles, and `flash_cs_n` is low in every one of them. TICKS = ceil(CLK_FREQ_HZ × PULSE_US / 1,000,000) with PULSE_US = 10 by default.
- R3: `flash_rst_n` and `flash_cs_n` return high in the same cycle at the end of the pulse.
- R4: After that release, `flash_cs_n` stays high for exactly TICKS+1 cycles before it falls for the status read. These cycles are the settling interval plus one cycle of chip-select toggle.
- R5: The status read performs exactly two byte transfers with `flash_cs_n` low. The first sends 0xD7 and the second sends 0x00. Each `xfer_start` lasts one cycle, and the second is raised only after `xfer_done` for the first.
- R6: The `xfer_rx` value presented with `xfer_done` for the second transfer appears on `status_byte`. The block waits for `xfer_done` for any latency.
- R7: `dev_pass` is set when status bits [5:2] equal EXPECT_CODE, whatever the other bits are. The default is 4'h9; the legal settings are 4'h7, 4'h9 and 4'h0B, matching 2048×264, 4096×264 and 4096×528 page geometries.
- R8: When the code differs, `dev_fail` is set instead. In DONE exactly one of the two flags is high.
- R9: `seq_done`, the flags and `status_byte` hold while no `start` arrives. A `start` in DONE clears `seq_done` and both flags in the following cycle and runs the whole sequence again.
- R10: A `start` pulse while the sequence is running is ignored: the reset pulse keeps its exact length.
- R11: `flash_cs_n` is high when `seq_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, accepted in IDLE or DONE |
| flash_rst_n | output | 1 | Active-low reset pin of the flash |
| flash_wp_n | output | 1 | Active-low write-protect pin, kept high |
| flash_cs_n | output | 1 | Active-low chip select of the flash |
| xfer_start | output | 1 | One-cycle request to exchange one byte |
| xfer_tx | output | 8 | Byte to send with the request |
| xfer_done | input | 1 | One-cycle completion of the byte exchange |
| xfer_rx | input | 8 | Byte received, valid with `xfer_done` |
| seq_done | output | 1 | Sequence finished |
| dev_pass | output | 1 | Size code matched |
| dev_fail | output | 1 | Size code did not match |
| status_byte | output | 8 | Captured status byte |

## Verification
The bench uses a clock frequency that gives a fractional number of cycles (250.5). A design that truncated instead of rounding up would produce a 250-cycle pulse where 251 are expected. It also counts the chip-select-high cycles between release and the first transfer; a design that skipped the toggle cycle, or that released reset and chip select in different cycles, is caught there. Status values are chosen with unrelated bits set and cleared around a matching code, so a design that compared the whole byte or used the wrong bit slice gives the wrong verdict. A mid-pulse `start` and slow transfer responses expose a design that restarts its timer or issues the second byte before the first completes.

// File: rtl/fb_pkg.sv
package fb_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ARM,
        S_RST_PULSE,
        S_SETTLE,
        S_CS_GAP,
        S_OP_ISSUE,
        S_OP_WAIT,
        S_DUM_ISSUE,
        S_DUM_WAIT,
        S_JUDGE,
        S_DONE
    } fb_state_t;

    localparam logic [7:0] STATUS_OPCODE = 8'hD7;
    localparam logic [7:0] FILL_BYTE     = 8'h00;
    localparam int unsigned CODE_LSB     = 2;
    localparam int unsigned CODE_W       = 4;

    // Whole clock cycles covering a span in microseconds, rounded up.
    function automatic int unsigned ticks_for(input int unsigned hz, input int unsigned us);
        logic [63:0] prod;
        prod = 64'(hz) * 64'(us);
        return 32'((prod + 64'd999_999) / 64'd1_000_000);
    endfunction

endpackage

// File: rtl/fb_interval_timer.sv
module fb_interval_timer #(
    parameter int unsigned TICKS = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int unsigned CNT_W = (TICKS < 2) ? 1 : $clog2(TICKS);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CNT_W'(TICKS - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    AST_TIMER_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> expired); // R2

endmodule

// File: rtl/fb_density_judge.sv
module fb_density_judge #(
    parameter logic [3:0] EXPECT_CODE = 4'h9,
    parameter int unsigned LSB = 2,
    parameter int unsigned WIDTH = 4
) (
    input  logic [7:0] stat,
    output logic       match
);
    logic [WIDTH-1:0] code;

    generate
        if (LSB + WIDTH <= 8) begin : g_slice
            assign code = stat[LSB +: WIDTH];
        end else begin : g_bad
            assign code = '1;
        end
    endgenerate

    assign match = (code == WIDTH'(EXPECT_CODE));

endmodule

// File: rtl/flash_bringup.sv
module flash_bringup
    import fb_pkg::*;
#(
    parameter int unsigned CLK_FREQ_HZ = 50_000_000,
    parameter int unsigned PULSE_US    = 10,
    parameter logic [3:0]  EXPECT_CODE = 4'h9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output logic       flash_rst_n,
    output logic       flash_wp_n,
    output logic       flash_cs_n,
    output logic       xfer_start,
    output logic [7:0] xfer_tx,
    input  logic       xfer_done,
    input  logic [7:0] xfer_rx,
    output logic       seq_done,
    output logic       dev_pass,
    output logic       dev_fail,
    output logic [7:0] status_byte
);
    localparam int unsigned TICKS = ticks_for(CLK_FREQ_HZ, PULSE_US);

    fb_state_t state_q, state_n;
    logic      tmr_load, tmr_expired, code_match;
    logic      accept;
    logic [7:0] stat_q;
    logic       pass_q, fail_q;

    assign accept = start && (state_q == S_IDLE || state_q == S_DONE);

    fb_interval_timer #(.TICKS(TICKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .expired (tmr_expired)
    );

    fb_density_judge #(
        .EXPECT_CODE (EXPECT_CODE),
        .LSB         (CODE_LSB),
        .WIDTH       (CODE_W)
    ) u_judge (
        .stat  (stat_q),
        .match (code_match)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_n;
    end

    // Next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_IDLE:      if (start) state_n = S_ARM;
            S_ARM:       state_n = S_RST_PULSE;
            S_RST_PULSE: if (tmr_expired) state_n = S_SETTLE;
            S_SETTLE:    if (tmr_expired) state_n = S_CS_GAP;
            S_CS_GAP:    state_n = S_OP_ISSUE;
            S_OP_ISSUE:  state_n = S_OP_WAIT;
            S_OP_WAIT:   if (xfer_done) state_n = S_DUM_ISSUE;
            S_DUM_ISSUE: state_n = S_DUM_WAIT;
            S_DUM_WAIT:  if (xfer_done) state_n = S_JUDGE;
            S_JUDGE:     state_n = S_DONE;
            S_DONE:      if (start) state_n = S_ARM;
            default:     state_n = S_IDLE;
        endcase
    end

    assign tmr_load = (state_n != state_q) &&
                      (state_n == S_RST_PULSE || state_n == S_SETTLE);

    // Outputs decoded from state
    always_comb begin
        flash_rst_n = 1'b1;
        flash_cs_n  = 1'b1;
        xfer_start  = 1'b0;
        xfer_tx     = FILL_BYTE;
        unique case (state_q)
            S_RST_PULSE: begin
                flash_rst_n = 1'b0;
                flash_cs_n  = 1'b0;
            end
            S_OP_ISSUE: begin
                flash_cs_n = 1'b0;
                xfer_start = 1'b1;
                xfer_tx    = STATUS_OPCODE;
            end
            S_OP_WAIT: begin
                flash_cs_n = 1'b0;
                xfer_tx    = STATUS_OPCODE;
            end
            S_DUM_ISSUE: begin
                flash_cs_n = 1'b0;
                xfer_start = 1'b1;
            end
            S_DUM_WAIT: begin
                flash_cs_n = 1'b0;
            end
            default: begin
            end
        endcase
    end

    assign flash_wp_n = 1'b1;
    assign seq_done   = (state_q == S_DONE);

    // Captured byte and verdict
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            pass_q <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            if (accept) begin
                pass_q <= 1'b0;
                fail_q <= 1'b0;
            end else if (state_q == S_JUDGE) begin
                pass_q <= code_match;
                fail_q <= !code_match;
            end
            if (state_q == S_DUM_WAIT && xfer_done) begin
                stat_q <= xfer_rx;
            end
        end
    end

    assign dev_pass    = pass_q;
    assign dev_fail    = fail_q;
    assign status_byte = stat_q;

    AST_PULSE_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_rst_n |-> !flash_cs_n); // R2
    AST_JOINT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_rst_n) |-> $rose(flash_cs_n)); // R3
    AST_XFER_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start); // R5
    AST_XFER_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> (!flash_cs_n && flash_rst_n)); // R5
    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> ($countones({dev_pass, dev_fail}) == 1)); // R8
    AST_VERDICT_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_pass || dev_fail) |-> seq_done); // R9
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && !start) |=> (seq_done && $stable(status_byte) && $stable(dev_pass))); // R9
    AST_CS_FREE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> flash_cs_n); // R11

endmodule

// File: tb/tb_flash_bringup.sv
module tb_flash_bringup;
    localparam int CLK_PERIOD = 10;
    localparam int unsigned HZ = 25_050_000;
    localparam longint EXP_TICKS = (longint'(HZ) * 10 + 999_999) / 1_000_000; // 251

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic flash_rst_n, flash_wp_n, flash_cs_n, xfer_start;
    logic [7:0] xfer_tx;
    logic xfer_done = 1'b0;
    logic [7:0] xfer_rx = 8'h00;
    logic seq_done, dev_pass, dev_fail;
    logic [7:0] status_byte;

    int n_checks = 0;
    int n_fails = 0;

    // Responder state
    logic [7:0] resp = 8'h00;
    int latency = 1;
    int txn = 0;
    int overlap = 0;
    logic [7:0] tx0 = 8'h00, tx1 = 8'h00;
    int pend = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_bringup #(.CLK_FREQ_HZ(HZ), .PULSE_US(10), .EXPECT_CODE(4'h9)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .flash_rst_n(flash_rst_n), .flash_wp_n(flash_wp_n), .flash_cs_n(flash_cs_n),
        .xfer_start(xfer_start), .xfer_tx(xfer_tx), .xfer_done(xfer_done), .xfer_rx(xfer_rx),
        .seq_done(seq_done), .dev_pass(dev_pass), .dev_fail(dev_fail), .status_byte(status_byte)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Byte-exchange responder
    initial begin
        forever begin
            @(negedge clk);
            xfer_done = 1'b0;
            if (pend > 0) begin
                if (xfer_start) overlap++;
                pend--;
                if (pend == 0) begin
                    xfer_done = 1'b1;
                    xfer_rx = (txn == 2) ? resp : 8'h5A;
                end
            end else if (xfer_start) begin
                if (txn == 0) tx0 = xfer_tx;
                else if (txn == 1) tx1 = xfer_tx;
                txn++;
                pend = latency;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    function automatic bit code_ok(input logic [7:0] s);
        return s[5:2] == 4'h9;
    endfunction

    task automatic test_reset_state();
        check(flash_rst_n && flash_wp_n && flash_cs_n, "R1 pins idle",
              {flash_rst_n, flash_wp_n, flash_cs_n}, 3'b111);
        check(!xfer_start && !seq_done && !dev_pass && !dev_fail, "R1 flags clear",
              {xfer_start, seq_done, dev_pass, dev_fail}, 0);
    endtask

    task automatic run_seq(input logic [7:0] st, input int lat, input bit poke);
        int low = 0, gap = 0, guard = 0, wp_bad = 0;
        bit seen_low = 0, released = 0, gap_done = 0, bad_cs = 0, joint_ok = 0;
        resp = st; latency = lat; txn = 0; overlap = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (!seq_done && guard < 5000) begin
            if (!flash_wp_n) wp_bad++;
            if (!flash_rst_n) begin
                low++;
                seen_low = 1;
                if (flash_cs_n) bad_cs = 1;
            end
            if (seen_low && flash_rst_n && !released) begin
                released = 1;
                joint_ok = flash_cs_n;
            end
            if (released && !gap_done) begin
                if (flash_cs_n) gap++;
                else gap_done = 1;
            end
            start = poke && (low == 3) && !flash_rst_n;
            @(negedge clk);
            guard++;
        end
        start = 1'b0;
        check(guard < 5000, "R6 completes", guard, 5000);
        check(low == EXP_TICKS, poke ? "R10 pulse unchanged by start" : "R2 pulse width", low, EXP_TICKS);
        check(!bad_cs, "R2 cs held in pulse", bad_cs, 0);
        check(joint_ok, "R3 joint release", joint_ok, 1);
        check(gap == EXP_TICKS + 1, "R4 settle gap", gap, EXP_TICKS + 1);
        check(txn == 2 && tx0 == 8'hD7 && tx1 == 8'h00, "R5 byte sequence", {txn[7:0], tx0, tx1}, 24'h02D700);
        check(overlap == 0, "R5 no early request", overlap, 0);
        check(status_byte == st, "R6 captured byte", status_byte, st);
        if (code_ok(st))
            check(dev_pass && !dev_fail, "R7 pass verdict", {dev_pass, dev_fail}, 2'b10);
        else
            check(!dev_pass && dev_fail, "R8 fail verdict", {dev_pass, dev_fail}, 2'b01);
        check(flash_cs_n, "R11 cs released", flash_cs_n, 1);
        check(wp_bad == 0, "R1 wp stays high", wp_bad, 0);
    endtask

    task automatic test_hold_restart();
        logic [7:0] held = status_byte;
        logic hp = dev_pass, hf = dev_fail;
        int guard = 0;
        repeat (20) @(negedge clk);
        check(seq_done && dev_pass == hp && dev_fail == hf && status_byte == held,
              "R9 results hold", {seq_done, dev_pass, dev_fail, status_byte}, {1'b1, hp, hf, held});
        resp = 8'h24; latency = 2; txn = 0;
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(!seq_done && !dev_pass && !dev_fail, "R9 restart clears",
              {seq_done, dev_pass, dev_fail}, 0);
        while (!seq_done && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        check(seq_done && dev_pass && status_byte == 8'h24, "R9 rerun result",
              {seq_done, dev_pass, status_byte}, {2'b11, 8'h24});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset_state();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        test_reset_state();
        run_seq(8'h24, 1, 1'b0);   // exact code
        run_seq(8'hE7, 4, 1'b0);   // code 9 with other bits set
        run_seq(8'h1C, 2, 1'b0);   // code 7
        run_seq(8'hFF, 7, 1'b0);   // code F
        run_seq(8'hA4, 3, 1'b1);   // start poked mid-pulse
        run_seq(8'h00, 1, 1'b0);   // code 0
        test_hold_restart();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule